// File: doc/BRIEF.md
# Transmit Descriptor Error-Recovery Walker

This block is the fetch side of a transmit DMA engine. It walks a ring of one-word transmit descriptors held in a synchronous memory. It reads each buffer named by an active descriptor one byte at a time from a second synchronous memory and presents the bytes to the MAC on a valid/ready stream. When a buffer has been sent in full, it writes the descriptor back with its ownership bit cleared. A frame may be split across several descriptors. A two-bit position code in each descriptor marks where that buffer sits in its frame.

The MAC can strobe a transmit error while a buffer is being streamed. When that happens, the walker stops the stream at once and does not abort the ring or retry the frame. It retires the descriptor it was working on. It then keeps reading the rest of the frame's descriptors and clears each one's ownership bit without sending any data. When it reaches the descriptor that closes the frame, it also writes two error flags into that descriptor in the same write. Once that write-back has happened, a level interrupt is raised if interrupts are enabled. Software clears the interrupt with a one-cycle clear pulse.

When the walker reads a descriptor that software does not own, it stops and waits for a transmit request. If it stops partway through retiring an errored frame, it carries on retiring when it is restarted.

Top module: `tx_desc_walker`

## Requirements
- R1: Each descriptor word uses this layout: bit 0 is ownership (1 = still to send), bits 2:1 are the position code, bit 3 is the ring-end flag, bit 4 is the error flag, bit 5 is the abort flag, bits 9:6 are the byte length, and bits 17:10 are the buffer start address. For an owned descriptor, the bytes at buffer addresses start, start+1, ... are sent in order. Each byte holds `tx_valid` and `tx_data` steady until `tx_ready` accepts it.
- R2: `tx_last` is high together with the final byte of a buffer whose position code has bit 0 set (01 = frame end, 11 = single-buffer frame). It is low on every other byte.
- R3: After a buffer has been sent without error, its descriptor is written back with bit 0 cleared and all other bits unchanged.
- R4: If `mac_err` is high while a buffer is being fetched or sent, that byte is not accepted. `tx_valid` is low from the next cycle on, and the current descriptor is written back with bit 0 cleared in that next cycle.
- R5: After an error, each following owned descriptor of the frame whose position code has bit 0 clear (00 continue, 10 first) is written back with only bit 0 cleared, and no data is sent for it.
- R6: The descriptor that closes the errored frame gets bit 0 cleared and bits 4 and 5 set in a single write. This is the next descriptor whose position code has bit 0 set, or the errored descriptor itself if its own code has bit 0 set. Once that write is made, the walker resumes normal sending with the next descriptor.
- R7: With `irq_en` high, `irq` rises in the cycle right after the closing write-back of R6, exactly once per errored frame. It stays high until a one-cycle `irq_clr` pulse.
- R8: With `irq_en` low, an errored frame leaves `irq` low.
- R9: After the descriptor with bit 3 set, the next descriptor is read from `ring_base`. Otherwise the next address is the current address plus one.
- R10: Reading a descriptor with bit 0 clear stops the walker. It makes no further descriptor access until `tx_start` is pulsed, and then it resumes at that same address.
- R11: `mac_err` has no effect outside a buffer fetch or send. It does not change any write-back and does not raise `irq`.
- R12: An owned descriptor with length 0 sends no bytes and is written back with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the ring pointer from `ring_base` |
| ring_base | input | 4 | Descriptor index where the ring starts |
| tx_start | input | 1 | Transmit request; restarts a stopped walker |
| irq_en | input | 1 | Error interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| irq | output | 1 | Error interrupt level |
| desc_req | output | 1 | Descriptor memory access strobe |
| desc_we | output | 1 | Descriptor access is a write |
| desc_addr | output | 4 | Descriptor index |
| desc_wdata | output | 18 | Descriptor write data |
| desc_rdata | input | 18 | Descriptor read data, valid the cycle after a read |
| buf_rd | output | 1 | Buffer byte read strobe |
| buf_addr | output | 8 | Buffer byte address |
| buf_rdata | input | 8 | Buffer byte, valid the cycle after a read |
| tx_data | output | 8 | Byte to MAC |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_last | output | 1 | Byte closes a frame |
| mac_err | input | 1 | Transmit error strobe from MAC |

## Verification
The walker is tried with:
- a single-buffer frame under a ready line that toggles every cycle, which separates byte ordering and holding from simple throughput;
- a four-buffer frame whose error lands in the second buffer, which shows whether the first buffer's write-back stays clean, whether the middle buffers are retired silently, and whether only the closing buffer gets the flags and the interrupt;
- a single-buffer frame that errors and is followed by a good frame, with interrupts off, which distinguishes the self-closing case from the walk-ahead case and shows that sending resumes afterwards;
- a ring wrap, an idle stop and restart, a stray error while idle, and a zero-length buffer, each of which isolates one address or control path.

// File: rtl/tdw_pkg.sv
// Shared descriptor field positions, position codes and walker states.
// Assumes one descriptor word per memory location, control bits in the low bits.
package tdw_pkg;
    localparam int ACT_B  = 0;    // ownership bit
    localparam int POS_LO = 1;    // two-bit position code
    localparam int RL_B   = 3;    // ring-end flag
    localparam int ERR_B  = 4;    // error flag written on frame close
    localparam int ABT_B  = 5;    // abort flag written on frame close
    localparam int LEN_LO = 6;    // byte length field starts here
    localparam int CTRL_W = 6;    // bits below the length field

    localparam logic [1:0] POS_MID   = 2'b00;
    localparam logic [1:0] POS_END   = 2'b01;
    localparam logic [1:0] POS_FIRST = 2'b10;
    localparam logic [1:0] POS_ONLY  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RWAIT,
        ST_BRD,
        ST_BWAIT,
        ST_SEND,
        ST_WB,
        ST_RETIRE
    } walk_st_t;
endpackage

// File: rtl/tdw_ptr.sv
// Ring pointer: holds the current descriptor index and steps or wraps it.
// Assumes adv is a one-cycle strobe issued with each descriptor write-back.
module tdw_ptr #(
    parameter int DESC_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DESC_AW-1:0] ring_base,
    input  logic               adv,
    input  logic               wrap,
    output logic [DESC_AW-1:0] ptr
);
    // Load base at reset, then step or wrap on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= ring_base;
        else if (adv)
            ptr <= wrap ? ring_base : ptr + DESC_AW'(1);
    end

    AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wrap) |=> (ptr == $past(ring_base))); // R9
    AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap) |=> (ptr == DESC_AW'($past(ptr) + DESC_AW'(1)))); // R9
    AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr)); // R10
endmodule

// File: rtl/tdw_irq.sv
// Error interrupt level: set by a frame-close write-back when enabled,
// cleared by a write-one-to-clear pulse. A set in the same cycle as a clear wins.
module tdw_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic en,
    input  logic clr,
    output logic irq
);
    // Hold the interrupt level between set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (set && en)
            irq <= 1'b1;
        else if (clr)
            irq <= 1'b0;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (set && en) |=> irq); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set && en)); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set && irq) |=> !irq); // R7
endmodule

// File: rtl/tdw_fsm.sv
// Walker sequencer: reads descriptors, streams owned buffers byte by byte,
// writes descriptors back, and on a MAC error retires the rest of the frame.
// Assumes both memories return read data exactly one cycle after the strobe.
module tdw_fsm
    import tdw_pkg::*;
#(
    parameter int DESC_AW = 4,
    parameter int LEN_W   = 4,
    parameter int BUF_AW  = 8,
    parameter int DESC_W  = CTRL_W + LEN_W + BUF_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_start,
    input  logic               mac_err,
    input  logic [DESC_AW-1:0] cur_ptr,
    output logic               desc_req,
    output logic               desc_we,
    output logic [DESC_AW-1:0] desc_addr,
    output logic [DESC_W-1:0]  desc_wdata,
    input  logic [DESC_W-1:0]  desc_rdata,
    output logic               buf_rd,
    output logic [BUF_AW-1:0]  buf_addr,
    input  logic [7:0]         buf_rdata,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_last,
    output logic               adv,
    output logic               wrap,
    output logic               irq_set
);
    localparam int BASE_LO = LEN_LO + LEN_W;

    walk_st_t            st;
    logic [DESC_W-1:0]   d_q;
    logic [LEN_W-1:0]    cnt;
    logic [7:0]          byte_q;
    logic                skip;

    logic [LEN_W-1:0]    d_len;
    logic [BUF_AW-1:0]   d_base;
    logic [LEN_W-1:0]    rd_len;
    logic                last_byte;
    logic                closes;
    logic                data_phase;

    // Decode fields of the latched and the incoming descriptor.
    always_comb begin
        d_len      = d_q[LEN_LO +: LEN_W];
        d_base     = d_q[BASE_LO +: BUF_AW];
        rd_len     = desc_rdata[LEN_LO +: LEN_W];
        last_byte  = (cnt == d_len - LEN_W'(1));
        closes     = d_q[POS_LO];
        data_phase = (st == ST_BRD) || (st == ST_BWAIT) || (st == ST_SEND);
    end

    // Sequence descriptor reads, byte fetches, sends and write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            d_q    <= '0;
            cnt    <= '0;
            byte_q <= '0;
            skip   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE:  if (tx_start) st <= ST_RD;
                ST_RD:    st <= ST_RWAIT;
                ST_RWAIT: begin
                    d_q <= desc_rdata;
                    cnt <= '0;
                    if (!desc_rdata[ACT_B])    st <= ST_IDLE;
                    else if (skip)             st <= ST_RETIRE;
                    else if (rd_len == '0)     st <= ST_WB;
                    else                       st <= ST_BRD;
                end
                ST_BRD:   st <= mac_err ? ST_RETIRE : ST_BWAIT;
                ST_BWAIT: begin
                    byte_q <= buf_rdata;
                    st     <= mac_err ? ST_RETIRE : ST_SEND;
                end
                ST_SEND: begin
                    if (mac_err) begin
                        st <= ST_RETIRE;
                    end else if (tx_ready) begin
                        if (last_byte) begin
                            st <= ST_WB;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                            st  <= ST_BRD;
                        end
                    end
                end
                ST_WB:     st <= ST_RD;
                ST_RETIRE: begin
                    skip <= !closes;
                    st   <= ST_RD;
                end
                default:   st <= ST_IDLE;
            endcase
        end
    end

    // Drive memory strobes, stream outputs and pointer/interrupt controls.
    always_comb begin
        desc_req   = (st == ST_RD) || (st == ST_WB) || (st == ST_RETIRE);
        desc_we    = (st == ST_WB) || (st == ST_RETIRE);
        desc_addr  = cur_ptr;
        desc_wdata = d_q;
        desc_wdata[ACT_B] = 1'b0;
        if (st == ST_RETIRE && closes) begin
            desc_wdata[ERR_B] = 1'b1;
            desc_wdata[ABT_B] = 1'b1;
        end
        buf_rd   = (st == ST_BRD);
        buf_addr = d_base + BUF_AW'(cnt);
        tx_valid = (st == ST_SEND);
        tx_data  = byte_q;
        tx_last  = (st == ST_SEND) && last_byte && closes;
        adv      = desc_we;
        wrap     = d_q[RL_B];
        irq_set  = (st == ST_RETIRE) && closes;
    end

    AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_err && data_phase) |=> (!tx_valid && desc_we && !desc_wdata[ACT_B])); // R4
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> !tx_valid); // R5
    AST_CLOSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && desc_wdata[ERR_B] && !d_q[ERR_B]) |-> (desc_wdata[POS_LO] && desc_wdata[ABT_B])); // R6
    AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> !desc_wdata[ACT_B]); // R3
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !mac_err) |=> (tx_valid && $stable(tx_data))); // R1
    AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !tx_start) |=> (st == ST_IDLE && !desc_req)); // R10
endmodule

// File: rtl/tx_desc_walker.sv
// Top of the transmit descriptor walker: ring pointer, sequencer and
// interrupt level. Assumes single-cycle-latency descriptor and buffer memories.
module tx_desc_walker
    import tdw_pkg::*;
#(
    parameter int DESC_AW = 4,
    parameter int LEN_W   = 4,
    parameter int BUF_AW  = 8,
    localparam int DESC_W = CTRL_W + LEN_W + BUF_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DESC_AW-1:0] ring_base,
    input  logic               tx_start,
    input  logic               irq_en,
    input  logic               irq_clr,
    output logic               irq,
    output logic               desc_req,
    output logic               desc_we,
    output logic [DESC_AW-1:0] desc_addr,
    output logic [DESC_W-1:0]  desc_wdata,
    input  logic [DESC_W-1:0]  desc_rdata,
    output logic               buf_rd,
    output logic [BUF_AW-1:0]  buf_addr,
    input  logic [7:0]         buf_rdata,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               tx_last,
    input  logic               mac_err
);
    logic [DESC_AW-1:0] cur_ptr;
    logic               adv;
    logic               wrap;
    logic               irq_set;

    tdw_ptr #(.DESC_AW(DESC_AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_base (ring_base),
        .adv       (adv),
        .wrap      (wrap),
        .ptr       (cur_ptr)
    );

    tdw_fsm #(
        .DESC_AW (DESC_AW),
        .LEN_W   (LEN_W),
        .BUF_AW  (BUF_AW),
        .DESC_W  (DESC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_start   (tx_start),
        .mac_err    (mac_err),
        .cur_ptr    (cur_ptr),
        .desc_req   (desc_req),
        .desc_we    (desc_we),
        .desc_addr  (desc_addr),
        .desc_wdata (desc_wdata),
        .desc_rdata (desc_rdata),
        .buf_rd     (buf_rd),
        .buf_addr   (buf_addr),
        .buf_rdata  (buf_rdata),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_last    (tx_last),
        .adv        (adv),
        .wrap       (wrap),
        .irq_set    (irq_set)
    );

    tdw_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .en    (irq_en),
        .clr   (irq_clr),
        .irq   (irq)
    );
endmodule

// File: tb/tx_desc_walker_test.sv
`timescale 1ns/1ps
// Directed bench: memory and MAC models, one task per scenario.
module tx_desc_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ring_base = '0;
    logic        tx_start = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
    logic        irq, desc_req, desc_we, buf_rd, tx_valid, tx_last;
    logic [3:0]  desc_addr;
    logic [17:0] desc_wdata, desc_rdata;
    logic [7:0]  buf_addr, buf_rdata, tx_data;
    logic        tx_ready = 1'b1, mac_err = 1'b0;

    tx_desc_walker uut (.*);

    always #10 clk = ~clk;   // 50 MHz

    // bench state
    int          tests = 0, fails = 0;
    logic [17:0] dmem [16];
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [17:0] ld_data = '0;
    int          cyc, nbytes, rd_count, err_cyc, txv_win, irq_rise, n_rise;
    int          wr_cyc [16];
    logic [3:0]  last_rd;
    logic [7:0]  got [32];
    logic        gotlast [32];
    logic        win, fired, irq_d;
    logic        rdy_mode = 1'b0, inj_arm = 1'b0, err_force = 1'b0;
    int          err_after = 0;
    logic        done = 1'b0;

    function automatic logic [7:0] bval(input logic [7:0] a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [17:0] mk(input logic act, input logic [1:0] pos,
                                       input logic rl, input logic [3:0] len,
                                       input logic [7:0] base);
        return {base, len, 2'b00, rl, pos, act};
    endfunction

    // Memories and MAC capture, all on the rising edge.
    always @(posedge clk) begin
        if (ld_en) dmem[ld_addr] <= ld_data;
        if (!rst_n) begin
            cyc <= 0; nbytes <= 0; rd_count <= 0; err_cyc <= -1; txv_win <= 0;
            irq_rise <= -1; n_rise <= 0; win <= 1'b0; fired <= 1'b0; irq_d <= 1'b0;
            last_rd <= '0;
            for (int i = 0; i < 16; i++) wr_cyc[i] <= -1;
        end else begin
            cyc <= cyc + 1;
            if (desc_req) begin
                if (desc_we) begin
                    dmem[desc_addr]   <= desc_wdata;
                    wr_cyc[desc_addr] <= cyc;
                    if (desc_wdata[5]) win <= 1'b0;
                end else begin
                    desc_rdata <= dmem[desc_addr];
                    rd_count   <= rd_count + 1;
                    last_rd    <= desc_addr;
                end
            end
            if (buf_rd) buf_rdata <= bval(buf_addr);
            if (tx_valid && tx_ready && !mac_err) begin
                got[nbytes]     <= tx_data;
                gotlast[nbytes] <= tx_last;
                nbytes          <= nbytes + 1;
            end
            if (tx_valid && mac_err) begin
                err_cyc <= cyc; win <= 1'b1; fired <= 1'b1;
            end
            if (win && tx_valid) txv_win <= txv_win + 1;
            if (irq && !irq_d) begin irq_rise <= cyc; n_rise <= n_rise + 1; end
            irq_d <= irq;
        end
    end

    // MAC drive on the falling edge.
    always @(negedge clk) begin
        tx_ready <= rdy_mode ? ~tx_ready : 1'b1;
        mac_err  <= err_force || (inj_arm && !fired && tx_valid && nbytes == err_after);
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] a, input logic [17:0] d);
        @(negedge clk); ld_addr = a; ld_data = d; ld_en = 1'b1;
        @(negedge clk); ld_en = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] base);
        @(negedge clk);
        ring_base = base; rst_n = 1'b0; inj_arm = 1'b0; err_force = 1'b0;
        rdy_mode = 1'b0; irq_en = 1'b0;
        for (int i = 0; i < 16; i++) load(4'(i), '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic kick();
        @(negedge clk); tx_start = 1'b1;
        @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic settle();
        int q = 0;
        for (int i = 0; i < 2000 && q < 10; i++) begin
            @(negedge clk);
            if (!desc_req && !tx_valid) q++; else q = 0;
        end
    endtask

    task automatic t_reset();
        do_reset(4'd0);
        @(negedge clk);
        check("R10 reset tx_valid", tx_valid, 0);
        check("R7 reset irq", irq, 0);
        check("R10 reset desc_req", desc_req, 0);
    endtask

    task automatic t_single_backpressure();
        do_reset(4'd0);
        load(0, mk(1, 2'b11, 0, 3, 8'h10));
        rdy_mode = 1'b1;
        kick(); settle();
        check("R1 byte count", nbytes, 3);
        for (int i = 0; i < 3; i++) check("R1 byte order", got[i], bval(8'(8'h10 + i)));
        check("R2 last flag off", gotlast[1], 0);
        check("R2 last flag on", gotlast[2], 1);
        check("R3 clean write-back", dmem[0], mk(0, 2'b11, 0, 3, 8'h10));
        check("R7 no irq on good frame", irq, 0);
    endtask

    task automatic t_multi_error();
        do_reset(4'd0);
        load(0, mk(1, 2'b10, 0, 4, 8'h20));
        load(1, mk(1, 2'b00, 0, 4, 8'h30));
        load(2, mk(1, 2'b00, 0, 4, 8'h40));
        load(3, mk(1, 2'b01, 0, 4, 8'h50));
        irq_en = 1'b1; err_after = 5; inj_arm = 1'b1;
        kick(); settle();
        check("R4 bytes before error", nbytes, 5);
        check("R4 last byte sent", got[4], bval(8'h30));
        check("R2 no last on partial frame", gotlast[3], 0);
        check("R3 first buffer clean", dmem[0], mk(0, 2'b10, 0, 4, 8'h20));
        check("R4 errored write-back", dmem[1], mk(0, 2'b00, 0, 4, 8'h30));
        check("R4 immediate write-back", wr_cyc[1], err_cyc + 1);
        check("R5 continuing retired", dmem[2], mk(0, 2'b00, 0, 4, 8'h40));
        check("R5 silent until close", txv_win, 0);
        check("R6 closing flags", dmem[3], mk(0, 2'b01, 0, 4, 8'h50) | 18'h30);
        check("R7 irq after close", irq_rise, wr_cyc[3] + 1);
        check("R7 single irq", n_rise, 1);
        check("R7 irq held", irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R7 irq cleared", irq, 0);
    endtask

    task automatic t_self_close();
        do_reset(4'd0);
        load(0, mk(1, 2'b11, 0, 3, 8'h60));
        load(1, mk(1, 2'b11, 0, 2, 8'h70));
        irq_en = 1'b0; err_after = 1; inj_arm = 1'b1;
        kick(); settle();
        check("R6 self-closing flags", dmem[0], mk(0, 2'b11, 0, 3, 8'h60) | 18'h30);
        check("R6 next frame sent", nbytes, 3);
        check("R6 next frame bytes", got[1], bval(8'h70));
        check("R6 next frame clean", dmem[1], mk(0, 2'b11, 0, 2, 8'h70));
        check("R8 irq stays low", n_rise, 0);
    endtask

    task automatic t_wrap_idle();
        do_reset(4'd12);
        load(12, mk(1, 2'b10, 0, 1, 8'h80));
        load(13, mk(1, 2'b01, 1, 1, 8'h81));
        kick(); settle();
        check("R9 reads through wrap", rd_count, 3);
        check("R9 wrapped address", last_rd, 12);
        check("R1 wrap bytes", nbytes, 2);
        repeat (20) @(negedge clk);
        check("R10 no access while stopped", rd_count, 3);
        load(12, mk(1, 2'b11, 0, 1, 8'h90));
        kick(); settle();
        check("R10 restart byte", got[2], bval(8'h90));
        check("R10 restart reads", rd_count, 5);
    endtask

    task automatic t_stray_error();
        do_reset(4'd0);
        irq_en = 1'b1;
        @(negedge clk); err_force = 1'b1;
        repeat (3) @(negedge clk);
        err_force = 1'b0;
        load(0, mk(1, 2'b11, 0, 2, 8'hA0));
        kick(); settle();
        check("R11 bytes sent", nbytes, 2);
        check("R11 clean write-back", dmem[0], mk(0, 2'b11, 0, 2, 8'hA0));
        check("R11 no irq", irq, 0);
    endtask

    task automatic t_zero_len();
        do_reset(4'd0);
        load(0, mk(1, 2'b11, 0, 0, 8'hB0));
        kick(); settle();
        check("R12 no bytes", nbytes, 0);
        check("R12 released", dmem[0], mk(0, 2'b11, 0, 0, 8'hB0));
        check("R12 reads", rd_count, 2);
    endtask

    initial begin
        t_reset();
        t_single_backpressure();
        t_multi_error();
        t_self_close();
        t_wrap_idle();
        t_stray_error();
        t_zero_len();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule